// File: doc/BRIEF.md
# Pulse Accumulator

The block is an 8-bit counter driven from a single external input pin. In event mode it counts transitions of one chosen direction on the pin. In gated mode it counts ticks of an internal divider while the pin is held at its chosen active level, so the final count measures how long the pin was held. A polarity bit picks the rising or falling edge in event mode, and the active-high or active-low level in gated mode.

The pin is asynchronous. It passes through a two-flop synchronizer before any edge or level decision is made. Software reaches the block through a small register port with three locations: control, counter and status. This port is plain control access with single-cycle writes, a combinational read and no handshake, so it never applies back-pressure. Two flags, counter wrap and input edge, are cleared by writing a one. Each flag drives its own interrupt line, which is gated by its own enable bit.

Top module: `pacc_top`

## Requirements
- R1: After reset, the control register, the counter, both flags and both interrupt outputs are all zero.
- R2: Register map (addr): 0 = control, 1 = counter, 2 = status, 3 reads zero. Control bits are: bit0 enable, bit1 gated mode, bit2 polarity, bit4 wrap interrupt enable, bit5 edge interrupt enable. The other control bits read as zero. Any value written to the counter reads back unchanged.
- R3: In event mode with enable set, each selected edge adds one to the counter. Polarity 0 selects rising edges and polarity 1 selects falling edges. The new count is visible after the third rising clock edge following the pin change.
- R4: While enable is clear, pin activity changes neither the counter nor either flag.
- R5: In gated mode the divider restarts whenever enable or gated mode is clear. The counter then adds one at every 64th clock (PRESCALE) after enable, but only while the synchronized pin is at its active level. Polarity 0 means active high and polarity 1 means active low.
- R6: In gated mode the counter holds its value while the pin is at its inactive level.
- R7: An increment from 0xFF wraps the counter to 0x00 and sets the wrap flag (status bit0). A count that only reaches 0xFF leaves the flag clear.
- R8: The edge flag (status bit1) sets on every counted edge in event mode. In gated mode it sets only on the trailing edge that ends the active level, and never on the leading edge.
- R9: Writing status with a bit set to one clears that flag. A zero bit leaves its flag unchanged.
- R10: `irq_wrap` is high exactly when the wrap flag and its enable are both set. `irq_edge` is high exactly when the edge flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous counted/gating input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational on addr) |
| irq_wrap | output | 1 | Counter wrap interrupt |
| irq_edge | output | 1 | Input edge interrupt |

## Verification
Event mode is exercised with a run of identical pulses for each polarity. A pin held at the edge of its pulse shows whether the rising or the falling transition is the one counted. Gated mode is driven with long active windows of each polarity that start after enable and are bracketed by idle time. This separates counting at the divider rate from counting every clock, and separates the trailing edge from the leading one. Wrap is swept from every start value between 0xF8 and 0xFF, so that reaching 0xFF is told apart from passing it, and flag clearing is tried with selective one bits.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
package pacc_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CB_EN      = 0;
  localparam int CB_GATED   = 1;
  localparam int CB_POL     = 2;
  localparam int CB_WRAP_IE = 4;
  localparam int CB_EDGE_IE = 5;

  localparam int SB_WRAP = 0;
  localparam int SB_EDGE = 1;

  typedef struct packed {
    logic edge_ie;
    logic wrap_ie;
    logic pol;
    logic gated;
    logic en;
  } pacc_ctrl_t;
endpackage

// File: rtl/pacc_insync.sv
`timescale 1ns/1ps
module pacc_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/pacc_divider.sv
`timescale 1ns/1ps
module pacc_divider #(
  parameter int PRESCALE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE == 1) begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign tick = run;
    end else begin : g_div
      localparam logic [DW-1:0] LAST = DW'(PRESCALE - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (!run)           div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = run & (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pacc_counter.sv
`timescale 1ns/1ps
module pacc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (inc)  count <= count + 1'b1;
  end

  assign wrap = inc & ~load & (count == ALL_ONES);
endmodule

// File: rtl/pacc_regs.sv
`timescale 1ns/1ps
module pacc_regs
  import pacc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] count,
  input  logic         wrap_set,
  input  logic         edge_set,
  output pacc_ctrl_t   ctrl,
  output logic         cnt_load,
  output logic         wrap_flag,
  output logic         edge_flag,
  output logic [W-1:0] rdata,
  output logic         irq_wrap,
  output logic         irq_edge
);
  logic ctrl_wr, stat_wr;
  logic [W-1:0] ctrl_view, stat_view;

  assign ctrl_wr  = wr_en & (addr == ADDR_CTRL);
  assign stat_wr  = wr_en & (addr == ADDR_STAT);
  assign cnt_load = wr_en & (addr == ADDR_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl.en      <= wdata[CB_EN];
      ctrl.gated   <= wdata[CB_GATED];
      ctrl.pol     <= wdata[CB_POL];
      ctrl.wrap_ie <= wdata[CB_WRAP_IE];
      ctrl.edge_ie <= wdata[CB_EDGE_IE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_flag <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      wrap_flag <= wrap_set | (wrap_flag & ~(stat_wr & wdata[SB_WRAP]));
      edge_flag <= edge_set | (edge_flag & ~(stat_wr & wdata[SB_EDGE]));
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CB_EN]      = ctrl.en;
    ctrl_view[CB_GATED]   = ctrl.gated;
    ctrl_view[CB_POL]     = ctrl.pol;
    ctrl_view[CB_WRAP_IE] = ctrl.wrap_ie;
    ctrl_view[CB_EDGE_IE] = ctrl.edge_ie;
    stat_view = '0;
    stat_view[SB_WRAP] = wrap_flag;
    stat_view[SB_EDGE] = edge_flag;
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdata = ctrl_view;
      ADDR_CNT:  rdata = count;
      ADDR_STAT: rdata = stat_view;
      default:   rdata = '0;
    endcase
  end

  assign irq_wrap = wrap_flag & ctrl.wrap_ie;
  assign irq_edge = edge_flag & ctrl.edge_ie;
endmodule

// File: rtl/pacc_top.sv
`timescale 1ns/1ps
module pacc_top
  import pacc_pkg::*;
#(
  parameter int W           = 8,
  parameter int PRESCALE    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_in,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq_wrap,
  output logic         irq_edge
);
  pacc_ctrl_t   ctrl;
  logic         lvl, rise, fall;
  logic         sel_edge, trail_edge, gate_active;
  logic         tick, inc, cnt_load, wrap, edge_set;
  logic         wrap_flag, edge_flag;
  logic [W-1:0] count;

  pacc_insync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  assign sel_edge    = ctrl.pol ? fall : rise;
  assign trail_edge  = ctrl.pol ? rise : fall;
  assign gate_active = lvl ^ ctrl.pol;

  pacc_divider #(.PRESCALE(PRESCALE)) div_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl.en & ctrl.gated), .tick(tick)
  );

  assign inc = ctrl.en & (ctrl.gated ? (tick & gate_active) : sel_edge);
  assign edge_set = ctrl.en & (ctrl.gated ? trail_edge : sel_edge);

  pacc_counter #(.W(W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .inc(inc), .load(cnt_load),
    .load_val(wdata), .count(count), .wrap(wrap)
  );

  pacc_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .count(count), .wrap_set(wrap), .edge_set(edge_set), .ctrl(ctrl),
    .cnt_load(cnt_load), .wrap_flag(wrap_flag), .edge_flag(edge_flag),
    .rdata(rdata), .irq_wrap(irq_wrap), .irq_edge(irq_edge)
  );
endmodule

// File: rtl/pacc_checker.sv
`timescale 1ns/1ps
module pacc_checker
  import pacc_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         gated,
  input logic         gate_active,
  input logic         cnt_load,
  input logic [W-1:0] count,
  input logic         wrap,
  input logic         wrap_flag,
  input logic         edge_flag,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_load) |=> $stable(count)); // R4

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_load) |=> (W'(count - $past(count)) <= W'(1))); // R3

  AST_GATE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gated && !gate_active && !cnt_load) |=> $stable(count)); // R6

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> wrap_flag); // R7

  AST_WRAP_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_STAT && wdata[SB_WRAP] && !wrap) |=> !wrap_flag); // R9

  AST_EDGE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !$rose(edge_flag)); // R8
endmodule

bind pacc_top pacc_checker #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(ctrl.en), .gated(ctrl.gated),
  .gate_active(gate_active), .cnt_load(cnt_load), .count(count),
  .wrap(wrap), .wrap_flag(wrap_flag), .edge_flag(edge_flag),
  .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/pacc_top_tb_top.sv
`timescale 1ns/1ps
module pacc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_wrap, irq_edge;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pacc_top dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_wrap(irq_wrap), .irq_edge(irq_edge)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    pin_in = 1'b1; idle(4);
    pin_in = 1'b0; idle(4);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    reg_rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    reg_rd(2'd1, v); chk("R1 count", v, 8'h00);
    reg_rd(2'd2, v); chk("R1 status", v, 8'h00);
    chk("R1 irq_wrap", irq_wrap, 0);
    chk("R1 irq_edge", irq_edge, 0);

    // R2 register map
    reg_wr(2'd1, 8'h5A); reg_rd(2'd1, v); chk("R2 count rw", v, 8'h5A);
    reg_wr(2'd0, 8'h34); reg_rd(2'd0, v); chk("R2 ctrl rw", v, 8'h34);
    reg_wr(2'd0, 8'hFF); reg_rd(2'd0, v); chk("R2 ctrl unused bits", v, 8'h37);
    reg_rd(2'd3, v); chk("R2 addr3 zero", v, 8'h00);
    reg_wr(2'd0, 8'h00);

    // R4 disabled: no count, no flag
    reg_wr(2'd1, 8'h00);
    for (int i = 0; i < 5; i++) pulse();
    reg_rd(2'd1, v); chk("R4 count held", v, 8'h00);
    reg_rd(2'd2, v); chk("R4 flags held", v, 8'h00);

    // R3 event mode, rising edges
    reg_wr(2'd0, 8'h01);
    for (int n = 1; n <= 10; n++) begin
      pulse();
      reg_rd(2'd1, v); chk("R3 rising count", v, n);
    end
    reg_rd(2'd2, v); chk("R8 edge flag event", v[1], 1);
    reg_wr(2'd2, 8'h00); reg_rd(2'd2, v); chk("R9 zero keeps flag", v[1], 1);
    reg_wr(2'd2, 8'h02); reg_rd(2'd2, v); chk("R9 w1c edge", v, 8'h00);
    pin_in = 1'b1; idle(6);
    reg_rd(2'd1, v); chk("R3 rising counts on rise", v, 11);
    pin_in = 1'b0; idle(6);
    reg_rd(2'd1, v); chk("R3 rising ignores fall", v, 11);

    // R3 event mode, falling edges
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd0, 8'h05);
    pin_in = 1'b1; idle(6);
    reg_rd(2'd1, v); chk("R3 falling ignores rise", v, 0);
    pin_in = 1'b0; idle(6);
    reg_rd(2'd1, v); chk("R3 falling counts on fall", v, 1);

    // R7 wrap sweep
    reg_wr(2'd0, 8'h01);
    for (int s = 8'hF8; s <= 8'hFF; s++) begin
      reg_wr(2'd1, 8'(s));
      reg_wr(2'd2, 8'h03);
      for (int k = 0; k < 255 - s; k++) pulse();
      reg_rd(2'd1, v); chk("R7 reach FF", v, 8'hFF);
      reg_rd(2'd2, v); chk("R7 no wrap at FF", v[0], 0);
      pulse();
      reg_rd(2'd1, v); chk("R7 wrap to 00", v, 8'h00);
      reg_rd(2'd2, v); chk("R7 wrap flag", v[0], 1);
    end
    chk("R10 irq_wrap masked", irq_wrap, 0);
    reg_wr(2'd0, 8'h11);
    chk("R10 irq_wrap enabled", irq_wrap, 1);
    reg_wr(2'd2, 8'h02);
    chk("R9 other bit keeps wrap", irq_wrap, 1);
    reg_wr(2'd2, 8'h01);
    chk("R9 w1c wrap", irq_wrap, 0);

    // R5/R6/R8 gated, active high
    reg_wr(2'd0, 8'h00);
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd2, 8'h03);
    reg_wr(2'd0, 8'h03);
    idle(20);
    reg_rd(2'd1, v); chk("R6 idle low no count", v, 0);
    pin_in = 1'b1;
    idle(329);
    reg_rd(2'd2, v); chk("R8 no flag on leading edge", v, 8'h00);
    pin_in = 1'b0;
    idle(100);
    reg_rd(2'd1, v); chk("R5 gated high count", v, 5);
    reg_rd(2'd2, v); chk("R8 trailing edge flag", v, 8'h02);
    chk("R10 irq_edge masked", irq_edge, 0);
    reg_wr(2'd0, 8'h23);
    chk("R10 irq_edge enabled", irq_edge, 1);

    // R5/R6 gated, active low
    reg_wr(2'd0, 8'h00);
    pin_in = 1'b1; idle(5);
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd2, 8'h03);
    reg_wr(2'd0, 8'h07);
    idle(20);
    reg_rd(2'd1, v); chk("R6 idle high no count", v, 0);
    pin_in = 1'b0;
    idle(199);
    pin_in = 1'b1;
    idle(100);
    reg_rd(2'd1, v); chk("R5 gated low count", v, 3);
    reg_rd(2'd2, v); chk("R8 trailing rise flag", v, 8'h02);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule